// File: doc/BRIEF.md
# Programmable Clock Skew Phase Generator

This block is a cycle-accurate, synchronous model of a clock phase generator with five banks. Its clock is a fast tick, and one tick stands for one time unit (tU). A frequency-range select sets how many ticks make up one nominal output period (N). Each bank produces a clock with a 50% duty cycle at that nominal rate. The rising edge of each bank clock is placed at a skew chosen by the bank's three-level phase selects.

There are four output banks and one feedback bank. Banks 1 and 2 offer a fine skew range. Banks 3 and 4 offer a wider range, and two of their codes copy the skew of bank 1 or bank 2. The feedback bank offers only three skews. The real loop locks the feedback output to the reference. To model that, the feedback bank's skew is subtracted from every bank, so the feedback clock always rises on phase zero and the other banks shift with it.

A reference pulse marks phase zero and starts the block after reset. Select changes are captured only at a period boundary, so no output ever produces a runt pulse.

Top module: `skew_phase_gen`

## Requirements
- R1: `fs_sel` sets the period N in ticks: 2'b00 gives 4*NBASE, 2'b10 gives NBASE, and 2'b01 or 2'b11 gives 2*NBASE. Each output repeats every N ticks.
- R2: Banks 1 and 2 each have a level pair (F1 at `f1_sel[2i+1:2i]`, F0 at `f0_sel[2i+1:2i]`, where i = bank number − 1). The code value is 3*F1+F0, with levels LOW=0, MID=1, HIGH=2. The skew is the code value minus 4, giving −4 to +4 tU.
- R3: Banks 3 and 4 use the same code value (0 to 8) to give −8, −7, −6, the skew of bank 1, 0, the skew of bank 2, +6, +7 and +8 tU, in that order.
- R4: The feedback select `fb_sel` gives −4 tU for 2'b00, 0 for 2'b01 and +4 tU for 2'b10.
- R5: `fb_clk` goes high on the first tick after the clock edge that samples `ref_tick` high. It also goes high at the start of every later period.
- R6: A bank clock rises (skew − feedback skew) mod N ticks after `fb_clk` rises. Negative values wrap into the previous period.
- R7: Each output is high for N/2 consecutive ticks per period and low for the rest.
- R8: Changes on `fs_sel`, `f1_sel`, `f0_sel` and `fb_sel` take effect only at a period boundary (the end of a period, or a `ref_tick`).
- R9: A synchronous `rst` holds all outputs low. They stay low until the first `ref_tick`. A `ref_tick` while running restarts phase zero.
- R10: The select level code 2'b11 is treated as MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tU per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | Reference pulse marking phase zero |
| fs_sel | input | 2 | Frequency-range select |
| f1_sel | input | 8 | Upper phase-select level for banks 1 to 4, 2 bits each |
| f0_sel | input | 8 | Lower phase-select level for banks 1 to 4, 2 bits each |
| fb_sel | input | 2 | Feedback bank phase-select level |
| bank_clk | output | 4 | Output clocks of banks 1 to 4 (bit 0 is bank 1) |
| fb_clk | output | 1 | Feedback bank clock |

## Verification
A corrupted phase counter or period register moves every output edge together. A wrongly latched select moves only the banks that decode it. In either case the first bad edge shows on the outputs within one period of N ticks. The bench compares every output on every tick against a behavioural model, so such a fault is reported on the tick where it first appears. Directed cases measure rise positions and high times across the wrap, the bank-copy codes and a mid-period change of range.

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
  parameter int NBASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic [1:0] fs_sel,
  input  logic [7:0] f1_sel,
  input  logic [7:0] f0_sel,
  input  logic [1:0] fb_sel,
  output logic [3:0] bank_clk,
  output logic       fb_clk
);
  localparam int NMAX = 4 * NBASE;
  localparam int CW = $clog2(NMAX) + 1;

  logic [CW-1:0] cnt, n_q;
  logic          started;
  logic [7:0]    f1_q, f0_q;
  logic [1:0]    fb_q;
  logic [4:0]    outs;
  logic          wrap;

  function automatic int lvl(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [CW-1:0] n_of(input logic [1:0] fs);
    case (fs)
      2'b00:   return CW'(4 * NBASE);
      2'b10:   return CW'(NBASE);
      default: return CW'(2 * NBASE);
    endcase
  endfunction

  assign wrap = started && (cnt == n_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      started <= 1'b0;
      n_q     <= n_of(2'b01);
      f1_q    <= 8'h55;
      f0_q    <= 8'h55;
      fb_q    <= 2'b01;
    end else if (ref_tick || wrap) begin
      cnt     <= '0;
      started <= 1'b1;
      n_q     <= n_of(fs_sel);
      f1_q    <= f1_sel;
      f0_q    <= f0_sel;
      fb_q    <= fb_sel;
    end else if (started) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    int c [4];
    int sk [5];
    int n;
    int ph;
    n = int'(n_q);
    for (int i = 0; i < 4; i++)
      c[i] = lvl(f1_q[2*i +: 2]) * 3 + lvl(f0_q[2*i +: 2]);
    sk[0] = c[0] - 4;
    sk[1] = c[1] - 4;
    for (int i = 2; i < 4; i++) begin
      case (c[i])
        0:       sk[i] = -8;
        1:       sk[i] = -7;
        2:       sk[i] = -6;
        3:       sk[i] = sk[0];
        4:       sk[i] = 0;
        5:       sk[i] = sk[1];
        6:       sk[i] = 6;
        7:       sk[i] = 7;
        default: sk[i] = 8;
      endcase
    end
    sk[4] = lvl(fb_q) * 4 - 4;
    for (int i = 0; i < 5; i++) begin
      ph = (int'(cnt) + sk[4] - sk[i] + 3 * n) % n;
      outs[i] = started && (ph < n / 2);
    end
  end

  assign bank_clk = outs[3:0];
  assign fb_clk   = outs[4];

  p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (rst)
    started |-> (cnt < n_q));

  p_fb_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (started && cnt == '0) |-> fb_clk);

  p_hold_low_r9: assert property (@(posedge clk) disable iff (rst)
    !started |-> (bank_clk == 4'b0 && !fb_clk));

  p_wait_ref_r9: assert property (@(posedge clk) disable iff (rst)
    (!started && !ref_tick) |=> !started);

  p_period_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (!ref_tick && !wrap) |=> ($stable(n_q) && $stable(f1_q) && $stable(f0_q) && $stable(fb_q)));
endmodule

// File: tb/skew_phase_gen_test.sv
module skew_phase_gen_test;
  localparam int NB = 16;
  logic clk = 0, rst = 1, ref_tick = 0;
  logic [1:0] fs_sel = 2'b01, fb_sel = 2'b01;
  logic [7:0] f1_sel = 8'h55, f0_sel = 8'h55;
  logic [3:0] bank_clk;
  logic fb_clk;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  skew_phase_gen #(.NBASE(NB)) uut (.clk, .rst, .ref_tick, .fs_sel, .f1_sel,
    .f0_sel, .fb_sel, .bank_clk, .fb_clk);

  always #10 clk = ~clk;

  int m_cnt = 0, m_n = 2 * NB, m_started = 0;
  int m_sk [5] = '{0, 0, 0, 0, 0};

  function automatic int lv(input logic [1:0] s);
    if (s == 2'b00) return 0;
    if (s == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int wide(input int code, input int b1, input int b2);
    int t [9];
    t = '{-8, -7, -6, 0, 0, 0, 6, 7, 8};
    if (code == 3) return b1;
    if (code == 5) return b2;
    return t[code];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_started = 0; m_n = 2 * NB;
      foreach (m_sk[i]) m_sk[i] = 0;
    end else if (ref_tick || (m_started != 0 && m_cnt == m_n - 1)) begin
      m_cnt = 0; m_started = 1;
      m_n = (fs_sel == 2'b00) ? 4 * NB : (fs_sel == 2'b10) ? NB : 2 * NB;
      m_sk[0] = 3 * lv(f1_sel[1:0]) + lv(f0_sel[1:0]) - 4;
      m_sk[1] = 3 * lv(f1_sel[3:2]) + lv(f0_sel[3:2]) - 4;
      m_sk[2] = wide(3 * lv(f1_sel[5:4]) + lv(f0_sel[5:4]), m_sk[0], m_sk[1]);
      m_sk[3] = wide(3 * lv(f1_sel[7:6]) + lv(f0_sel[7:6]), m_sk[0], m_sk[1]);
      m_sk[4] = 4 * lv(fb_sel) - 4;
    end else if (m_started != 0) begin
      m_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [4:0] got;
    got = {fb_clk, bank_clk};
    for (int i = 0; i < 5; i++) begin
      int pos, e;
      pos = (m_cnt - (m_sk[i] - m_sk[4]) + 8 * m_n) % m_n;
      e = (m_started != 0 && pos < m_n / 2) ? 1 : 0;
      check(i < 2 ? "R2 model" : i < 4 ? "R3 model" : "R5 model", int'(got[i]), e);
    end
  end

  task automatic pulse_ref();
    @(negedge clk) ref_tick = 1;
    @(negedge clk) ref_tick = 0;
  endtask

  task automatic measure(input int idx, input int n, input int exp_rise, input string req);
    logic s [];
    int rise, highs;
    s = new[n];
    pulse_ref();
    repeat (n) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [4:0] g;
      g = {fb_clk, bank_clk};
      s[k] = g[idx];
      @(negedge clk);
    end
    rise = -1; highs = 0;
    for (int k = 0; k < n; k++) begin
      if (s[k]) highs++;
      if (s[k] && !s[(k + n - 1) % n]) rise = k;
    end
    check({req, " rise"}, rise, exp_rise);
    check("R7 duty", highs, n / 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset low", int'({fb_clk, bank_clk}), 0);
    rst = 0;
    repeat (4) @(negedge clk);
    check("R9 idle low", int'({fb_clk, bank_clk}), 0);
    pulse_ref();
    check("R5 fb first tick", int'(fb_clk), 1);

    fs_sel = 2'b10; fb_sel = 2'b01; f1_sel[1:0] = 2'b10; f0_sel[1:0] = 2'b10;
    measure(0, NB, 4, "R2 R6 bank1 +4");
    measure(4, NB, 0, "R5 fb");

    fs_sel = 2'b01; fb_sel = 2'b00; f1_sel[5:4] = 2'b10; f0_sel[5:4] = 2'b10;
    measure(2, 2 * NB, 12, "R4 R6 bank3 +8 fb -4");

    fs_sel = 2'b10; fb_sel = 2'b10; f1_sel[1:0] = 2'b00; f0_sel[1:0] = 2'b00;
    measure(0, NB, 8, "R6 wrap");

    fs_sel = 2'b00; fb_sel = 2'b01; f1_sel[1:0] = 2'b10; f0_sel[1:0] = 2'b01;
    f1_sel[5:4] = 2'b01; f0_sel[5:4] = 2'b00;
    measure(2, 4 * NB, 3, "R1 R3 bank3 copies bank1");

    fs_sel = 2'b10; f1_sel[3:2] = 2'b00; f0_sel[3:2] = 2'b01;
    f1_sel[7:6] = 2'b01; f0_sel[7:6] = 2'b10;
    measure(3, NB, 13, "R3 bank4 copies bank2");

    fs_sel = 2'b11; fb_sel = 2'b11; f1_sel[1:0] = 2'b11; f0_sel[1:0] = 2'b11;
    measure(0, 2 * NB, 0, "R10 illegal as MID");

    fs_sel = 2'b10; fb_sel = 2'b01;
    pulse_ref();
    fs_sel = 2'b00;
    repeat (8) @(negedge clk);
    check("R8 old period held", int'(fb_clk), 0);
    repeat (16) @(negedge clk);
    check("R8 new period applied", int'(fb_clk), 1);
    repeat (20) @(negedge clk);
    pulse_ref();
    check("R9 ref restarts", int'(fb_clk), 1);
    repeat (70) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule